// File: doc/BRIEF.md
# Shared Bus Ownership Arbiter

This block decides who drives a shared external bus: one of several processors on the same bus, or an external host. Each processor has its own active-low request line, and the host has a single active-low request that always wins over them. A hardwired identifier, captured only while reset is held, tells the block which processor request line belongs to the local node. When the local node owns the bus, the block raises the enable for the node's address, data, select and strobe drivers.

A host takeover runs as a handshake. The drivers are switched off first, and the active-low grant follows one cycle later. The grant then stays low for as long as the host keeps its request low. On release, the grant rises first, and the drivers may come back only on the cycle after that. A separate active-low suspend input switches the drivers off for the next cycle without any grant. While the bus cannot be driven, a local access attempt is held as halted. A host-ready output adds wait states while the host both selects the chip and requests the bus.

Top module: `bus_owner_arb`

## Requirements
- R1: The identifier is latched only while `rst` is high. Values 0 and 1 map the local node to request line 1 (`proc_req_n[0]`). A value k from 2 to 6 maps it to line k (`proc_req_n[k-1]`). Value 7 maps to no line, so the node never owns the bus. Changing the identifier after reset has no effect. `own_bus` is high exactly when the processor master is the local node's line.
- R2: While the host handshake is idle and `host_req_n` is high, the current processor master keeps the bus for as long as its request stays low. Otherwise the lowest-index asserted request becomes master on the next edge, or there is no master. `master_oh` is one-hot or zero.
- R3: The host has priority. If `host_req_n` is low at an edge, `drv_en` is low after that edge, whatever the processor requests are. `master_oh` does not change while the host handshake is not idle.
- R4: `host_grant_n` falls exactly one cycle after `drv_en` has been low because of a host request. The grant falls two edges after the request is first sampled low.
- R5: Once granted, `host_grant_n` stays low for as long as `host_req_n` stays low.
- R6: After `host_req_n` is sampled high, `host_grant_n` rises after that edge. `drv_en` stays low in that cycle and can return at the earliest one cycle later.
- R7: If `suspend_n` is low at an edge, `drv_en` is low for the following cycle. This causes no change to `host_grant_n`.
- R8: A local access attempt (`acc_req` high at an edge) gives `acc_go` high after that edge if the bus is driven in that cycle. Otherwise it gives `acc_halt` high. The two are never high together, and the access completes only once suspend and any host ownership have ended.
- R9: `host_rdy` is low one cycle after an edge at which both `host_cs_n` and `host_req_n` are low, and high otherwise.
- R10: While reset is held: `drv_en`=0, `host_grant_n`=1, `host_rdy`=1, `master_oh`=0, `acc_go`=0, `acc_halt`=0.
- R11: `drv_en` and a low `host_grant_n` never occur in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; identifier captured while high |
| id_strap | input | ID_W | Hardwired node identifier |
| proc_req_n | input | NUM_PROC | Active-low processor bus requests, line 1 at bit 0 |
| host_req_n | input | 1 | Active-low host bus request |
| host_cs_n | input | 1 | Active-low host chip select |
| suspend_n | input | 1 | Active-low suspend; floats drivers next cycle |
| acc_req | input | 1 | Local external access attempt |
| master_oh | output | NUM_PROC | One-hot current processor master, zero if none |
| own_bus | output | 1 | Local node is the processor master |
| drv_en | output | 1 | Enable for address, data, select and strobe drivers |
| host_grant_n | output | 1 | Active-low host grant |
| host_rdy | output | 1 | Host ready; low inserts wait states |
| acc_go | output | 1 | Local access proceeds this cycle |
| acc_halt | output | 1 | Local access halted this cycle |

## Verification
The interesting collision is a suspend pulse that lands during a host takeover or release. The same applies to a local access attempt that arrives in the same cycle as either of them. In that case the driver enable has three reasons to stay low, and the halt must cover all of them. The bench causes these collisions in directed sequences, by lowering `suspend_n` on the release edge and on the request edge. It then adds a long random stretch on all inputs. Each cycle is judged against a behavioural model of the handshake states and mastership, with particular attention to whether `drv_en` comes back in the correct cycle after the grant rises.

// File: rtl/bus_arb_pkg.sv
package bus_arb_pkg;
  typedef enum logic [1:0] {
    HS_BUS   = 2'd0,
    HS_FLOAT = 2'd1,
    HS_HOST  = 2'd2,
    HS_REL   = 2'd3
  } hand_st_t;
endpackage

// File: rtl/bus_arb_idlatch.sv
module bus_arb_idlatch #(
  parameter int NUM_PROC = 6,
  parameter int ID_W     = 3
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [ID_W-1:0]     id_strap,
  output logic [NUM_PROC-1:0] line_oh
);
  logic [NUM_PROC-1:0] dec;

  // identifier 0 shares line 1 with identifier 1 (single-processor use)
  for (genvar i = 0; i < NUM_PROC; i++) begin : g_dec
    if (i == 0) begin : g_first
      assign dec[i] = (int'(id_strap) == 1) || (int'(id_strap) == 0);
    end else begin : g_rest
      assign dec[i] = (int'(id_strap) == i + 1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) line_oh <= dec;
  end
endmodule

// File: rtl/bus_arb_prio.sv
module bus_arb_prio #(
  parameter int NUM_PROC = 6
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                upd_en,
  input  logic [NUM_PROC-1:0] req_n,
  output logic [NUM_PROC-1:0] master_nxt,
  output logic [NUM_PROC-1:0] master_q
);
  logic [NUM_PROC-1:0] req;
  logic [NUM_PROC-1:0] lowest;
  logic                keep;

  always_comb begin
    req    = ~req_n;
    lowest = req & (~req + NUM_PROC'(1));
    keep   = |(master_q & req);
    if (!upd_en)   master_nxt = master_q;
    else if (keep) master_nxt = master_q;
    else           master_nxt = lowest;
  end

  always_ff @(posedge clk) begin
    if (rst) master_q <= '0;
    else     master_q <= master_nxt;
  end
endmodule

// File: rtl/bus_arb_handover.sv
module bus_arb_handover
  import bus_arb_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic host_req_n,
  input  logic host_cs_n,
  input  logic suspend_n,
  input  logic acc_req,
  input  logic own_nxt,
  output logic upd_en,
  output logic drv_en,
  output logic host_grant_n,
  output logic host_rdy,
  output logic acc_go,
  output logic acc_halt
);
  hand_st_t st_q, st_nxt;
  logic     en_nxt;

  always_comb begin
    unique case (st_q)
      HS_BUS:   st_nxt = host_req_n ? HS_BUS : HS_FLOAT;
      HS_FLOAT: st_nxt = host_req_n ? HS_REL : HS_HOST;
      HS_HOST:  st_nxt = host_req_n ? HS_REL : HS_HOST;
      default:  st_nxt = host_req_n ? HS_BUS : HS_FLOAT;
    endcase
    upd_en = (st_q == HS_BUS) && host_req_n;
    en_nxt = (st_nxt == HS_BUS) && own_nxt && suspend_n;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q         <= HS_BUS;
      drv_en       <= 1'b0;
      host_grant_n <= 1'b1;
      host_rdy     <= 1'b1;
      acc_go       <= 1'b0;
      acc_halt     <= 1'b0;
    end else begin
      st_q         <= st_nxt;
      drv_en       <= en_nxt;
      host_grant_n <= (st_nxt != HS_HOST);
      host_rdy     <= host_cs_n || host_req_n;
      acc_go       <= acc_req && en_nxt;
      acc_halt     <= acc_req && !en_nxt;
    end
  end
endmodule

// File: rtl/bus_owner_arb.sv
module bus_owner_arb #(
  parameter int NUM_PROC = 6,
  parameter int ID_W     = 3
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [ID_W-1:0]     id_strap,
  input  logic [NUM_PROC-1:0] proc_req_n,
  input  logic                host_req_n,
  input  logic                host_cs_n,
  input  logic                suspend_n,
  input  logic                acc_req,
  output logic [NUM_PROC-1:0] master_oh,
  output logic                own_bus,
  output logic                drv_en,
  output logic                host_grant_n,
  output logic                host_rdy,
  output logic                acc_go,
  output logic                acc_halt
);
  logic [NUM_PROC-1:0] line_oh;
  logic [NUM_PROC-1:0] master_nxt;
  logic                upd_en;
  logic                own_nxt;

  bus_arb_idlatch #(.NUM_PROC(NUM_PROC), .ID_W(ID_W)) u_id (
    .clk(clk), .rst(rst), .id_strap(id_strap), .line_oh(line_oh)
  );

  bus_arb_prio #(.NUM_PROC(NUM_PROC)) u_prio (
    .clk(clk), .rst(rst), .upd_en(upd_en), .req_n(proc_req_n),
    .master_nxt(master_nxt), .master_q(master_oh)
  );

  assign own_nxt = |(master_nxt & line_oh);
  assign own_bus = |(master_oh & line_oh);

  bus_arb_handover u_hand (
    .clk(clk), .rst(rst), .host_req_n(host_req_n), .host_cs_n(host_cs_n),
    .suspend_n(suspend_n), .acc_req(acc_req), .own_nxt(own_nxt),
    .upd_en(upd_en), .drv_en(drv_en), .host_grant_n(host_grant_n),
    .host_rdy(host_rdy), .acc_go(acc_go), .acc_halt(acc_halt)
  );
endmodule

// File: rtl/bus_owner_arb_chk.sv
module bus_owner_arb_chk #(
  parameter int NUM_PROC = 6
) (
  input logic                clk,
  input logic                rst,
  input logic [NUM_PROC-1:0] proc_req_n,
  input logic                host_req_n,
  input logic                host_cs_n,
  input logic                suspend_n,
  input logic                acc_req,
  input logic [NUM_PROC-1:0] master_oh,
  input logic                drv_en,
  input logic                host_grant_n,
  input logic                host_rdy,
  input logic                acc_go,
  input logic                acc_halt
);
  p_master_onehot_r2: assert property (@(posedge clk) disable iff (rst)
    $onehot0(master_oh));
  p_host_first_r3: assert property (@(posedge clk) disable iff (rst)
    !host_req_n |=> !drv_en);
  p_grant_after_float_r4: assert property (@(posedge clk) disable iff (rst)
    $fell(host_grant_n) |-> !$past(drv_en));
  p_grant_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (!host_grant_n && !host_req_n) |=> !host_grant_n);
  p_release_gap_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(host_grant_n) |-> !drv_en);
  p_suspend_float_r7: assert property (@(posedge clk) disable iff (rst)
    !suspend_n |=> !drv_en);
  p_halt_on_suspend_r8: assert property (@(posedge clk) disable iff (rst)
    (!suspend_n && acc_req) |=> (acc_halt && !acc_go));
  p_go_halt_excl_r8: assert property (@(posedge clk) disable iff (rst)
    !(acc_go && acc_halt));
  p_wait_state_r9: assert property (@(posedge clk) disable iff (rst)
    (!host_cs_n && !host_req_n) |=> !host_rdy);
  p_no_contention_r11: assert property (@(posedge clk) disable iff (rst)
    !(drv_en && !host_grant_n));
endmodule

bind bus_owner_arb bus_owner_arb_chk #(.NUM_PROC(NUM_PROC)) u_chk (
  .clk(clk), .rst(rst), .proc_req_n(proc_req_n), .host_req_n(host_req_n),
  .host_cs_n(host_cs_n), .suspend_n(suspend_n), .acc_req(acc_req),
  .master_oh(master_oh), .drv_en(drv_en), .host_grant_n(host_grant_n),
  .host_rdy(host_rdy), .acc_go(acc_go), .acc_halt(acc_halt)
);

// File: tb/sim_bus_owner_arb.sv
`timescale 1ns/1ps
module sim_bus_owner_arb;
  localparam int NP = 6;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [2:0]    id_strap = 3'd0;
  logic [NP-1:0] proc_req_n = '1;
  logic          host_req_n = 1'b1, host_cs_n = 1'b1, suspend_n = 1'b1, acc_req = 1'b0;
  logic [NP-1:0] master_oh;
  logic          own_bus, drv_en, host_grant_n, host_rdy, acc_go, acc_halt;

  int n_chk = 0, n_bad = 0;
  bit checking = 1'b0;

  always #2.5 clk = ~clk;

  bus_owner_arb #(.NUM_PROC(NP), .ID_W(3)) u0 (
    .clk(clk), .rst(rst), .id_strap(id_strap), .proc_req_n(proc_req_n),
    .host_req_n(host_req_n), .host_cs_n(host_cs_n), .suspend_n(suspend_n),
    .acc_req(acc_req), .master_oh(master_oh), .own_bus(own_bus),
    .drv_en(drv_en), .host_grant_n(host_grant_n), .host_rdy(host_rdy),
    .acc_go(acc_go), .acc_halt(acc_halt)
  );

  // behavioural reference: handshake phase 0 idle,1 floating,2 granted,3 releasing
  int hs = 0, mst = -1, myl = 1;
  bit e_en = 0, e_gn = 1, e_rdy = 1, e_go = 0, e_halt = 0;

  always @(posedge clk) begin
    int nhs, nm;
    bit own_n;
    if (rst) begin
      hs = 0; mst = -1; e_en = 0; e_gn = 1; e_rdy = 1; e_go = 0; e_halt = 0;
      if (id_strap == 0)     myl = 1;
      else if (id_strap > 6) myl = 0;
      else                   myl = int'(id_strap);
    end else begin
      e_rdy = !(host_cs_n == 0 && host_req_n == 0);
      if (hs == 0)      nhs = host_req_n ? 0 : 1;
      else if (hs == 3) nhs = host_req_n ? 0 : 1;
      else              nhs = host_req_n ? 3 : 2;
      nm = mst;
      if (hs == 0 && host_req_n) begin
        if (!(mst >= 0 && proc_req_n[mst] == 0)) begin
          nm = -1;
          for (int k = NP - 1; k >= 0; k--) if (proc_req_n[k] == 0) nm = k;
        end
      end
      mst = nm;
      hs = nhs;
      e_gn = (hs != 2);
      own_n = (myl > 0) && (mst == myl - 1);
      e_en = (hs == 0) && own_n && suspend_n;
      e_go = acc_req && e_en;
      e_halt = acc_req && !e_en;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s at %0t: actual %0d expected %0d", tag, $time, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (checking && !rst) begin
      logic [NP-1:0] em;
      bit eo;
      em = (mst < 0) ? '0 : NP'(1) << mst;
      eo = (myl > 0) && (mst == myl - 1);
      chk(own_bus == eo, "R1 own_bus", int'(own_bus), int'(eo));
      chk(master_oh == em, "R2 master_oh", int'(master_oh), int'(em));
      chk(drv_en == e_en, "R3 R7 drv_en", int'(drv_en), int'(e_en));
      chk(host_grant_n == e_gn, "R4 R5 R6 host_grant_n", int'(host_grant_n), int'(e_gn));
      chk(acc_go == e_go && acc_halt == e_halt, "R8 acc_go/halt",
          int'({acc_go, acc_halt}), int'({e_go, e_halt}));
      chk(host_rdy == e_rdy, "R9 host_rdy", int'(host_rdy), int'(e_rdy));
      chk(!(drv_en && !host_grant_n), "R11 overlap", int'({drv_en, host_grant_n}), 1);
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset(input logic [2:0] idv);
    @(negedge clk);
    rst = 1'b1; id_strap = idv;
    proc_req_n = '1; host_req_n = 1; host_cs_n = 1; suspend_n = 1; acc_req = 0;
    cyc(2);
    // R10: reset values seen while reset is held
    chk(drv_en == 0 && host_grant_n == 1 && host_rdy == 1 && master_oh == 0 &&
        acc_go == 0 && acc_halt == 0, "R10 reset state",
        int'({drv_en, host_grant_n, host_rdy, acc_go, acc_halt}), 8'b01100);
    rst = 1'b0;
  endtask

  task automatic handover(input int hold);
    host_req_n = 0; cyc(1);
    host_req_n = 0; cyc(1);
    // R4: grant low two edges after request was first sampled
    chk(host_grant_n == 0 && drv_en == 0, "R4 grant timing", int'(host_grant_n), 0);
    cyc(hold);
    chk(host_grant_n == 0, "R5 grant held", int'(host_grant_n), 0);
    host_req_n = 1; cyc(1);
    chk(host_grant_n == 1 && drv_en == 0, "R6 release gap",
        int'({host_grant_n, drv_en}), 2);
    cyc(1);
  endtask

  initial begin
    do_reset(3'd0);
    checking = 1'b1;
    // R2 arbitration patterns, local line is 1 (bit 0)
    proc_req_n = 6'b111110; acc_req = 1; cyc(3);
    proc_req_n = 6'b110100; cyc(3);
    proc_req_n = 6'b110101; cyc(3);
    proc_req_n = 6'b111101; cyc(2);
    proc_req_n = 6'b111110; cyc(3);
    // R3 host takeover while owning, with processor requests active
    handover(4);
    handover(0);
    // R7 suspend pulse, R8 halt while suspended
    suspend_n = 0; cyc(1);
    chk(drv_en == 0 && acc_halt == 1, "R7 R8 suspend halts", int'({drv_en, acc_halt}), 1);
    cyc(2); suspend_n = 1; cyc(2);
    chk(acc_go == 1, "R8 access completes after suspend", int'(acc_go), 1);
    // suspend colliding with host request and release edges
    suspend_n = 0; host_req_n = 0; cyc(1); suspend_n = 1; cyc(3);
    host_req_n = 1; suspend_n = 0; cyc(1); suspend_n = 1; cyc(3);
    // R9 wait states
    host_cs_n = 0; host_req_n = 0; cyc(1);
    chk(host_rdy == 0, "R9 wait state", int'(host_rdy), 0);
    host_cs_n = 1; cyc(2); host_req_n = 1; cyc(3);
    // R1 identifier change after reset ignored
    id_strap = 3'd4; cyc(3);
    chk(own_bus == 1, "R1 id change ignored", int'(own_bus), 1);
    do_reset(3'd3);
    proc_req_n = 6'b111011; cyc(2);
    chk(own_bus == 1, "R1 id 3 maps to line 3", int'(own_bus), 1);
    proc_req_n = 6'b111110; cyc(4);
    do_reset(3'd7);
    proc_req_n = 6'b000000; cyc(3);
    chk(own_bus == 0, "R1 id 7 never owns", int'(own_bus), 0);
    do_reset(3'd1);
    for (int i = 0; i < 3000; i++) begin
      proc_req_n = ($urandom % 3 == 0) ? 6'($urandom) : proc_req_n;
      host_req_n = ($urandom % 8 == 0) ? ~host_req_n : host_req_n;
      host_cs_n = 1'($urandom);
      suspend_n = ($urandom % 6 != 0);
      acc_req = 1'($urandom);
      if (i == 1500) id_strap = 3'd2;
      cyc(1);
    end
    checking = 1'b0;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 5);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired: actual running expected finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule